// File: doc/BRIEF.md
# Serial Transmitter with Pin Handoff

This block is the sending side of a serial port. Software puts a byte into a single holding register. The byte then moves into a shift register and leaves on the output line. A flag shows whether the holding register is free. Two framings are supported. The first is asynchronous: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The second is clocked synchronous: eight data bits go out together with a serial clock output. Each bit lasts a fixed number of pulses of an external bit-rate tick.

An enable bit decides who owns the line. When the enable is set, the shifter drives the line. When it is clear, a software port data bit and a direction bit drive it. This lets software park the line high (mark) or hold it low (break). Clearing the enable stops a frame at once. In synchronous mode, no new transfer starts while a receive error reported by the neighbouring receiver is still pending. After reset, a halt bit freezes the whole interface until software clears it.

Top module: `ser_tx_pinmux_top`

## Requirements
- R1: After reset, the data-empty flag and the transmit-end flag read 1. The line is not driven (txd_oe=0). The serial clock output is high and not driven (sck_oe=0).
- R2: While transmission is disabled, txd_oe follows the port direction bit (control bit 2). When the direction bit is 1, txd_o follows the port data bit (control bit 3). Direction 1 with data 1 gives a steady mark level.
- R3: In asynchronous mode (control bit 1 = 0), a frame is one 0 start bit, then 8 data bits with bit 0 first, then one 1 stop bit. Each bit lasts TICKS_PER_BIT baud ticks.
- R4: Bit timing advances only on cycles where baud_tick is high. With a tick on every other cycle, every bit lasts twice as many clock cycles.
- R5: A write to the data register (address 1) clears the empty flag. The flag returns to 1 when the byte moves into the shift register.
- R6: A second write to the data register while a byte is still pending replaces that byte. Only the newer byte is sent, and only once.
- R7: Writing 1 to bit 0 of address 2 clears the empty flag. The byte already held is then sent again.
- R8: Clearing the enable (control bit 0) in the middle of a frame hands the line to the port bits on the next cycle. With port data 0, this holds a break. The frame is dropped, the transmit-end flag goes to 1, and re-enabling sends nothing.
- R9: In synchronous mode (control bit 1 = 1, enable = 1), sck_oe is 1 and the clock idles high. Each bit is put on the line together with a falling clock edge and holds while the clock is high. Eight bits go out, bit 0 first.
- R10: In synchronous mode, no transfer starts while any bit of rx_err is 1. The pending byte is sent once rx_err returns to 0. In asynchronous mode, rx_err does not hold back a start.
- R11: The halt bit (address 3, bit 0) resets to 1. While it is 1, writes to addresses 0, 1 and 2 are ignored. Address 3 can always be written.
- R12: The transmit-end flag goes to 1 when a frame ends with no byte pending. It goes to 0 when a byte is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 data, 2 flag clear, 3 halt |
| wr_data | input | 8 | Write data |
| baud_tick | input | 1 | Bit-rate tick; bit timing counts these pulses |
| rx_err | input | 3 | Receive error flags held by the receiver (overrun, framing, parity) |
| txd_o | output | 1 | Serial line output value |
| txd_oe | output | 1 | Serial line output enable |
| sck_o | output | 1 | Serial clock output value |
| sck_oe | output | 1 | Serial clock output enable |
| tdr_empty | output | 1 | Data register empty flag |
| tx_end | output | 1 | Transmit-end flag |

## Verification
The bench builds the block with TICKS_PER_BIT set to 4 and DATA_W set to 8. This makes a full asynchronous frame last 40 cycles, so tests for back-to-back traffic, overwrite, re-send and abort all run in a short time. Splitting each bit into two halves of 2 ticks lets the bench see every falling and rising clock edge in synchronous mode. Running with a half-rate tick shows that the bit timing depends on the tick, not on the clock.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_DATA  = 2'd1;
    localparam logic [1:0] ADDR_FLAG  = 2'd2;
    localparam logic [1:0] ADDR_HALT  = 2'd3;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_SYNC = 1;
    localparam int CTRL_DIR  = 2;
    localparam int CTRL_DAT  = 3;

endpackage

// File: rtl/ser_tx_regs.sv
module ser_tx_regs
    import ser_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              load_i,
    output logic              halt_o,
    output logic              en_o,
    output logic              sync_o,
    output logic              pdir_o,
    output logic              pdat_o,
    output logic [DATA_W-1:0] hold_o,
    output logic              empty_o
);

    typedef struct packed {
        logic              halt;
        logic              en;
        logic              sync;
        logic              pdir;
        logic              pdat;
        logic [DATA_W-1:0] hold;
        logic              empty;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // The load is applied first, so that a write in the same cycle leaves new data pending.
        if (load_i) begin
            r_d.empty = 1'b1;
        end
        if (wr_en) begin
            if (wr_addr == ADDR_HALT) begin
                r_d.halt = wr_data[0];
            end else if (!r_q.halt) begin
                case (wr_addr)
                    ADDR_CTRL: begin
                        r_d.en   = wr_data[CTRL_EN];
                        r_d.sync = wr_data[CTRL_SYNC];
                        r_d.pdir = wr_data[CTRL_DIR];
                        r_d.pdat = wr_data[CTRL_DAT];
                    end
                    ADDR_DATA: begin
                        r_d.hold  = wr_data[DATA_W-1:0];
                        r_d.empty = 1'b0;
                    end
                    ADDR_FLAG: begin
                        if (wr_data[0]) begin
                            r_d.empty = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.halt  <= 1'b1;
            r_q.en    <= 1'b0;
            r_q.sync  <= 1'b0;
            r_q.pdir  <= 1'b0;
            r_q.pdat  <= 1'b0;
            r_q.hold  <= '0;
            r_q.empty <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign halt_o  = r_q.halt;
    assign en_o    = r_q.en;
    assign sync_o  = r_q.sync;
    assign pdir_o  = r_q.pdir;
    assign pdat_o  = r_q.pdat;
    assign hold_o  = r_q.hold;
    assign empty_o = r_q.empty;

endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
    import ser_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              sync_i,
    input  logic              baud_tick,
    input  logic [DATA_W-1:0] hold_i,
    input  logic              empty_i,
    input  logic [2:0]        rx_err_i,
    output logic              load_o,
    output logic              line_o,
    output logic              sck_o,
    output logic              busy_o,
    output logic              tx_end_o
);

    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(TICKS_PER_BIT / 2);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] sh;
        logic              line;
        logic              tx_end;
    } shf_t;

    shf_t s_d, s_q;
    logic start_ok;
    logic bit_done;

    always_comb begin
        start_ok = !(sync_i && (|rx_err_i));
        load_o   = enable_i && (s_q.st == ST_IDLE) && !empty_i && start_ok;
        bit_done = baud_tick && (s_q.cnt == CNT_LAST);
        s_d      = s_q;

        if (!enable_i) begin
            s_d.st     = ST_IDLE;
            s_d.cnt    = '0;
            s_d.bitn   = '0;
            s_d.line   = 1'b1;
            s_d.tx_end = 1'b1;
        end else begin
            if (baud_tick && !bit_done && s_q.st != ST_IDLE) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            case (s_q.st)
                ST_IDLE: begin
                    if (!sync_i) begin
                        s_d.line = 1'b1;
                    end
                    if (load_o) begin
                        s_d.sh     = hold_i;
                        s_d.cnt    = '0;
                        s_d.bitn   = '0;
                        s_d.tx_end = 1'b0;
                        if (sync_i) begin
                            s_d.st   = ST_DATA;
                            s_d.line = hold_i[0];
                        end else begin
                            s_d.st   = ST_START;
                            s_d.line = 1'b0;
                        end
                    end
                end
                ST_START: begin
                    if (bit_done) begin
                        s_d.cnt  = '0;
                        s_d.st   = ST_DATA;
                        s_d.line = s_q.sh[0];
                    end
                end
                ST_DATA: begin
                    if (bit_done) begin
                        s_d.cnt = '0;
                        if (s_q.bitn == BIT_LAST) begin
                            if (sync_i) begin
                                s_d.st     = ST_IDLE;
                                s_d.tx_end = empty_i;
                            end else begin
                                s_d.st   = ST_STOP;
                                s_d.line = 1'b1;
                            end
                        end else begin
                            s_d.bitn = s_q.bitn + 1'b1;
                            s_d.sh   = s_q.sh >> 1;
                            s_d.line = s_q.sh[1];
                        end
                    end
                end
                ST_STOP: begin
                    if (bit_done) begin
                        s_d.cnt    = '0;
                        s_d.st     = ST_IDLE;
                        s_d.tx_end = empty_i;
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_IDLE;
            s_q.cnt    <= '0;
            s_q.bitn   <= '0;
            s_q.sh     <= '0;
            s_q.line   <= 1'b1;
            s_q.tx_end <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_o   = s_q.line;
    assign sck_o    = !(sync_i && (s_q.st == ST_DATA) && (s_q.cnt < CNT_HALF));
    assign busy_o   = (s_q.st != ST_IDLE);
    assign tx_end_o = s_q.tx_end;

endmodule

// File: rtl/ser_tx_pinsel.sv
module ser_tx_pinsel (
    input  logic enable_i,
    input  logic sync_i,
    input  logic line_i,
    input  logic sck_i,
    input  logic pdir_i,
    input  logic pdat_i,
    output logic txd_o,
    output logic txd_oe,
    output logic sck_o,
    output logic sck_oe
);

    always_comb begin
        if (enable_i) begin
            txd_o  = line_i;
            txd_oe = 1'b1;
        end else begin
            txd_o  = pdir_i ? pdat_i : 1'b1;
            txd_oe = pdir_i;
        end
        sck_oe = enable_i && sync_i;
        sck_o  = sck_oe ? sck_i : 1'b1;
    end

endmodule

// File: rtl/ser_tx_pinmux_top.sv
module ser_tx_pinmux_top #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       baud_tick,
    input  logic [2:0] rx_err,
    output logic       txd_o,
    output logic       txd_oe,
    output logic       sck_o,
    output logic       sck_oe,
    output logic       tdr_empty,
    output logic       tx_end
);

    logic              halt_w;
    logic              en_w;
    logic              sync_w;
    logic              pdir_w;
    logic              pdat_w;
    logic [DATA_W-1:0] hold_w;
    logic              empty_w;
    logic              load_w;
    logic              line_w;
    logic              sck_w;
    logic              busy_w;
    logic              run_en;

    assign run_en = en_w && !halt_w;

    ser_tx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load_i  (load_w),
        .halt_o  (halt_w),
        .en_o    (en_w),
        .sync_o  (sync_w),
        .pdir_o  (pdir_w),
        .pdat_o  (pdat_w),
        .hold_o  (hold_w),
        .empty_o (empty_w)
    );

    ser_tx_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (run_en),
        .sync_i    (sync_w),
        .baud_tick (baud_tick),
        .hold_i    (hold_w),
        .empty_i   (empty_w),
        .rx_err_i  (rx_err),
        .load_o    (load_w),
        .line_o    (line_w),
        .sck_o     (sck_w),
        .busy_o    (busy_w),
        .tx_end_o  (tx_end)
    );

    ser_tx_pinsel u_pins (
        .enable_i (run_en),
        .sync_i   (sync_w),
        .line_i   (line_w),
        .sck_i    (sck_w),
        .pdir_i   (pdir_w),
        .pdat_i   (pdat_w),
        .txd_o    (txd_o),
        .txd_oe   (txd_oe),
        .sck_o    (sck_o),
        .sck_oe   (sck_oe)
    );

    assign tdr_empty = empty_w;

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              busy,
    input logic              run_en,
    input logic              sync_mode,
    input logic [2:0]        rx_err,
    input logic              empty,
    input logic              tx_end,
    input logic              sck_o,
    input logic              halt,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] hold,
    input logic              en_bit
);

    a_r5_load_frees_register: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> empty);

    a_r10_no_start_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && sync_mode) |-> ($past(rx_err) == 3'b000));

    a_r12_end_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tx_end);

    a_r8_abort_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !busy);

    a_r9_clock_idles_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_o);

    a_r11_halt_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && wr_en && wr_addr != 2'd3) |=> ($stable(hold) && $stable(en_bit)));

endmodule

bind ser_tx_pinmux_top ser_tx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_w),
    .busy      (busy_w),
    .run_en    (run_en),
    .sync_mode (sync_w),
    .rx_err    (rx_err),
    .empty     (empty_w),
    .tx_end    (tx_end),
    .sck_o     (sck_o),
    .halt      (halt_w),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .hold      (hold_w),
    .en_bit    (en_w)
);

// File: tb/ser_tx_pinmux_top_test.sv
`timescale 1ns/1ps
module ser_tx_pinmux_top_test;

    localparam int TPB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       baud_tick = 1'b1;
    logic [2:0] rx_err = 3'b000;
    logic       txd_o, txd_oe, sck_o, sck_oe, tdr_empty, tx_end;
    logic       slow_tick = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (slow_tick) baud_tick <= ~baud_tick;
        else           baud_tick <= 1'b1;
    end

    ser_tx_pinmux_top #(.DATA_W(8), .TICKS_PER_BIT(TPB)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .baud_tick(baud_tick), .rx_err(rx_err), .txd_o(txd_o), .txd_oe(txd_oe),
        .sck_o(sck_o), .sck_oe(sck_oe), .tdr_empty(tdr_empty), .tx_end(tx_end)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rx_async(input int bitcyc, output logic [7:0] d, output bit ok);
        int n = 0;
        logic sb, pb;
        ok = 1'b0; d = 8'h00;
        while (!(txd_oe === 1'b1 && txd_o === 1'b0) && n < 400) begin
            @(negedge clk); n++;
        end
        if (n >= 400) return;
        repeat (bitcyc / 2) @(negedge clk);
        sb = txd_o;
        for (int k = 0; k < 8; k++) begin
            repeat (bitcyc) @(negedge clk);
            d[k] = txd_o;
        end
        repeat (bitcyc) @(negedge clk);
        pb = txd_o;
        ok = (sb === 1'b0) && (pb === 1'b1);
    endtask

    task automatic rx_sync(output logic [7:0] d, output int got, output int bad);
        int n = 0;
        logic ps, pt;
        d = 8'h00; got = 0; bad = 0;
        ps = sck_o; pt = txd_o;
        while (got < 8 && n < 400) begin
            @(negedge clk); n++;
            if (ps === 1'b0 && sck_o === 1'b1) begin
                d[got] = txd_o; got++;
            end
            if (ps === 1'b1 && sck_o === 1'b1 && txd_o !== pt) bad++;
            ps = sck_o; pt = txd_o;
        end
    endtask

    task automatic t_reset;
        chk(tdr_empty === 1'b1, "R1 empty", tdr_empty, 1);
        chk(tx_end === 1'b1, "R1 tx_end", tx_end, 1);
        chk(txd_oe === 1'b0, "R1 txd_oe", txd_oe, 0);
        chk(sck_o === 1'b1 && sck_oe === 1'b0, "R1 sck", {sck_o, sck_oe}, 2'b10);
    endtask

    task automatic t_halt;
        wr(2'd0, 8'h0D);
        chk(txd_oe === 1'b0, "R11 ctrl write ignored", txd_oe, 0);
        wr(2'd1, 8'h77);
        chk(tdr_empty === 1'b1, "R11 data write ignored", tdr_empty, 1);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h0C);
        chk(txd_oe === 1'b1, "R11 ctrl writable after halt cleared", txd_oe, 1);
        chk(tdr_empty === 1'b1, "R11 nothing pending", tdr_empty, 1);
    endtask

    task automatic t_port;
        wr(2'd0, 8'h0C);
        chk(txd_oe === 1'b1 && txd_o === 1'b1, "R2 mark", {txd_oe, txd_o}, 2'b11);
        wr(2'd0, 8'h04);
        chk(txd_oe === 1'b1 && txd_o === 1'b0, "R2 port low", {txd_oe, txd_o}, 2'b10);
        wr(2'd0, 8'h08);
        chk(txd_oe === 1'b0, "R2 tri-state", txd_oe, 0);
    endtask

    task automatic t_async;
        logic [7:0] d; bit ok;
        wr(2'd0, 8'h0D);
        wr(2'd1, 8'hA5);
        chk(tdr_empty === 1'b0, "R5 pending after write", tdr_empty, 0);
        @(negedge clk);
        chk(tdr_empty === 1'b1, "R5 empty after load", tdr_empty, 1);
        chk(tx_end === 1'b0, "R12 cleared on load", tx_end, 0);
        rx_async(TPB, d, ok);
        chk(ok && d == 8'hA5, "R3 async frame", d, 8'hA5);
        repeat (TPB) @(negedge clk);
        chk(tx_end === 1'b1, "R12 set after stop", tx_end, 1);
    endtask

    task automatic t_overwrite;
        logic [7:0] d; bit ok; int hi = 0;
        wr(2'd0, 8'h0C);
        wr(2'd1, 8'h11);
        wr(2'd1, 8'h3C);
        chk(tdr_empty === 1'b0, "R6 pending", tdr_empty, 0);
        wr(2'd0, 8'h0D);
        rx_async(TPB, d, ok);
        chk(ok && d == 8'h3C, "R6 newer byte sent", d, 8'h3C);
        repeat (60) begin @(negedge clk); if (txd_o === 1'b1) hi++; end
        chk(hi == 60, "R6 sent once", hi, 60);
    endtask

    task automatic t_resend;
        logic [7:0] d; bit ok;
        wr(2'd2, 8'h01);
        chk(tdr_empty === 1'b0, "R7 flag cleared", tdr_empty, 0);
        rx_async(TPB, d, ok);
        chk(ok && d == 8'h3C, "R7 held byte resent", d, 8'h3C);
        repeat (TPB) @(negedge clk);
    endtask

    task automatic t_slow;
        logic [7:0] d; bit ok;
        slow_tick = 1'b1;
        wr(2'd1, 8'h5A);
        rx_async(2 * TPB, d, ok);
        chk(ok && d == 8'h5A, "R4 half-rate tick frame", d, 8'h5A);
        repeat (2 * TPB) @(negedge clk);
        slow_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_abort;
        int lo = 0; int hi = 0;
        wr(2'd1, 8'hFF);
        repeat (10) @(negedge clk);
        wr(2'd0, 8'h04);
        chk(txd_oe === 1'b1 && txd_o === 1'b0, "R8 break on abort", {txd_oe, txd_o}, 2'b10);
        @(negedge clk);
        chk(tx_end === 1'b1, "R8 tx_end after abort", tx_end, 1);
        repeat (40) begin @(negedge clk); if (txd_o === 1'b0) lo++; end
        chk(lo == 40, "R8 break held", lo, 40);
        wr(2'd0, 8'h0D);
        repeat (60) begin @(negedge clk); if (txd_o === 1'b1) hi++; end
        chk(hi == 60 && tdr_empty === 1'b1, "R8 dropped frame not resent", hi, 60);
    endtask

    task automatic t_sync;
        logic [7:0] d; int got, bad;
        wr(2'd0, 8'h0F);
        chk(sck_oe === 1'b1 && sck_o === 1'b1, "R9 clock idle high", {sck_oe, sck_o}, 2'b11);
        wr(2'd1, 8'h96);
        rx_sync(d, got, bad);
        chk(got == 8 && d == 8'h96, "R9 sync byte", d, 8'h96);
        chk(bad == 0, "R9 data stable while clock high", bad, 0);
        repeat (TPB + 2) @(negedge clk);
        chk(sck_o === 1'b1 && tx_end === 1'b1, "R12 sync end idle", {sck_o, tx_end}, 2'b11);
    endtask

    task automatic t_interlock;
        logic [7:0] d; int got, bad; int idle = 0; bit ok;
        rx_err = 3'b010;
        wr(2'd1, 8'h33);
        repeat (40) begin @(negedge clk); if (sck_o === 1'b1) idle++; end
        chk(idle == 40 && tdr_empty === 1'b0, "R10 held off by error", idle, 40);
        rx_err = 3'b000;
        rx_sync(d, got, bad);
        chk(got == 8 && d == 8'h33, "R10 sent after error cleared", d, 8'h33);
        repeat (TPB + 2) @(negedge clk);
        wr(2'd0, 8'h0D);
        rx_err = 3'b111;
        wr(2'd1, 8'hC3);
        rx_async(TPB, d, ok);
        chk(ok && d == 8'hC3, "R10 async not blocked", d, 8'hC3);
        rx_err = 3'b000;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_halt();
        t_port();
        t_async();
        t_overwrite();
        t_resend();
        t_slow();
        t_abort();
        t_sync();
        t_interlock();
        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule